// File: doc/BRIEF.md
# Dual Timer/Counter with Split Mode

This block holds two 16-bit timer/counters. Each one is built from a high byte and a low byte. Each timer takes its count events from one of two sources: a one-cycle enable that the clock divider raises once every twelve oscillator periods, or falling edges on its external count pin. A per-timer configuration nibble selects the following:

- gating by an external interrupt level;
- the event source;
- one of four counting modes: 13-bit, 16-bit, 8-bit with automatic reload, or split.

When a timer wraps, it sets its overflow flag. A flag stays set until the interrupt logic pulses the matching clear input, which it does when it vectors to the service routine. Timer 1 wraps also appear as a registered pulse, which a serial baud-rate divider can use as its clock.

In split mode, timer 0 becomes two independent 8-bit counters. The low byte keeps timer 0's controls and flag. The high byte counts divider ticks under timer 1's run bit and drives timer 1's flag. While this routing is active, timer 1 can still count and still produce baud pulses, but it can no longer touch its flag. Software loads the count bytes through a byte-wide write port.

Top module: `tmr_pair_top`

## Requirements
- R1: After a synchronous reset, both counts, both flags and the baud pulse are zero.
- R2: The configuration nibble for timer i is mode_cfg_i[4i+3:4i], laid out as {gate, source, mode[1:0]}.
  - Source 0 counts each cycle in which tick_i is high.
  - Source 1 counts one event per 1-to-0 transition of the synchronized count pin, and tick_i has no effect.
- R3: A timer counts only when its run bit is 1 and either its gate bit is 0 or its synchronized interrupt pin is high. Otherwise its count holds.
- R4: Mode 00 counts the 13-bit value {high byte, low[4:0]}. It wraps from 0x1FFF to 0 and sets the flag. Low bits [7:5] are left unchanged.
- R5: Mode 01 counts the full 16-bit value. It wraps from 0xFFFF to 0 and sets the flag.
- R6: Mode 10 counts only the low byte. When the low byte steps past 0xFF, it is loaded from the high byte and the flag is set. The high byte is unchanged.
- R7: Mode 11 on timer 0 works as two 8-bit counters.
  - The low byte counts under timer 0's run, gate and source, and sets flag 0 when it wraps.
  - The high byte counts tick_i under run_i[1] and sets flag 1 when it wraps.
- R8: While timer 0 is in mode 11, a timer 1 wrap does not set flag 1.
- R9: Timer 1 in mode 11 holds its count and produces neither a flag nor a baud pulse.
- R10: flag_clr_i[i] clears flag i on the next edge. A set in the same cycle wins over the clear.
- R11: baud_pulse_o is high for the cycle after each edge at which timer 1 wraps, whatever timer 0's mode is.
- R12: wr_sel_i is a one-hot byte select.
  - Bit 0 selects timer 0 low, bit 1 timer 0 high, bit 2 timer 1 low and bit 3 timer 1 high.
  - A selected byte takes wr_data_i on the edge.
  - In that cycle the written timer does not count.
- R13: The count outputs present {high byte, low byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Divide-by-12 count enable |
| mode_cfg_i | input | 8 | Two configuration nibbles; timer 0 in the low nibble |
| run_i | input | 2 | Run bits, one per timer |
| cnt_pin_i | input | 2 | External count pins (asynchronous) |
| irq_pin_i | input | 2 | External interrupt pins used for gating (asynchronous) |
| wr_sel_i | input | 4 | One-hot byte write select |
| wr_data_i | input | 8 | Byte write data |
| flag_clr_i | input | 2 | Flag clear on vectoring |
| t0_cnt_o | output | 16 | Timer 0 {high, low} |
| t1_cnt_o | output | 16 | Timer 1 {high, low} |
| flag_o | output | 2 | Overflow flags |
| baud_pulse_o | output | 1 | Timer 1 overflow pulse |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 5-bit low prescaler field and two synchronizer stages. With these values, preloading counts just below each wrap point puts the 13-bit and 16-bit wraps, and several auto-reload periods, within a few hundred ticks.

The sweep runs both timers through:
- modes 00, 01 and 10;
- four preloads;
- four run lengths.

For each combination, the bench computes the count and flag arithmetically. Directed sequences then cover split routing, timer 1 holding in mode 11, gating, pin-edge counting, flag clear priority, write suppression and baud pulse counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_13B    = 2'b00,
    TM_16B    = 2'b01,
    TM_RELOAD = 2'b10,
    TM_SPLIT  = 2'b11
  } tmr_mode_e;

  localparam int CFG_W = 4;
  localparam int NUM_T = 2;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2   // at least 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_mode_e         mode_i,
  input  logic              inc_lo_i,
  input  logic              inc_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              ovf_hi_o
);
  localparam logic [PRE_W-1:0]    PRE_ONE  = 1;
  localparam logic [BYTE_W-1:0]   BYTE_ONE = 1;
  localparam logic [2*BYTE_W-1:0] WORD_ONE = 1;

  logic [BYTE_W-1:0]   lo_q, hi_q, lo_n, hi_n;
  logic [2*BYTE_W-1:0] word_n;
  logic                any_wr, cnt_lo, cnt_hi;

  assign any_wr = wr_lo_i | wr_hi_i;
  assign cnt_lo = inc_lo_i & ~any_wr;
  assign cnt_hi = inc_hi_i & ~any_wr;

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_o    = 1'b0;
    ovf_hi_o = 1'b0;
    word_n   = {hi_q, lo_q} + WORD_ONE;
    unique case (mode_i)
      TM_13B: if (cnt_lo) begin
        if (&lo_q[PRE_W-1:0]) begin
          lo_n[PRE_W-1:0] = '0;
          hi_n            = hi_q + BYTE_ONE;
          ovf_o           = &hi_q;
        end else begin
          lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_ONE;
        end
      end
      TM_16B: if (cnt_lo) begin
        {hi_n, lo_n} = word_n;
        ovf_o        = &{hi_q, lo_q};
      end
      TM_RELOAD: if (cnt_lo) begin
        if (&lo_q) begin
          lo_n  = hi_q;
          ovf_o = 1'b1;
        end else begin
          lo_n  = lo_q + BYTE_ONE;
        end
      end
      TM_SPLIT: begin
        if (cnt_lo) begin
          lo_n  = lo_q + BYTE_ONE;
          ovf_o = &lo_q;
        end
        if (cnt_hi) begin
          hi_n     = hi_q + BYTE_ONE;
          ovf_hi_o = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo_i) lo_n = wr_data_i;
    if (wr_hi_i) hi_n = wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R4
  wrap13_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !any_wr && mode_i == TM_13B) |=> (hi_q == '0 && lo_q[PRE_W-1:0] == '0));
  // R5
  wrap16_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !any_wr && mode_i == TM_16B) |=> ({hi_q, lo_q} == '0));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !any_wr && mode_i == TM_RELOAD) |=> (lo_q == $past(hi_q) && $stable(hi_q)));
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic [2*CFG_W-1:0]  mode_cfg_i,
  input  logic [1:0]          run_i,
  input  logic [1:0]          cnt_pin_i,
  input  logic [1:0]          irq_pin_i,
  input  logic [3:0]          wr_sel_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  input  logic [1:0]          flag_clr_i,
  output logic [2*BYTE_W-1:0] t0_cnt_o,
  output logic [2*BYTE_W-1:0] t1_cnt_o,
  output logic [1:0]          flag_o,
  output logic                baud_pulse_o
);
  logic [NUM_T-1:0]  cnt_lvl, cnt_prev, cnt_fall, irq_lvl;
  logic [NUM_T-1:0]  gate, src, en, ev;
  tmr_mode_e         md [NUM_T];
  logic [NUM_T-1:0]  inc_lo, inc_hi, ovf, ovf_hi;
  logic [BYTE_W-1:0] lo_w [NUM_T];
  logic [BYTE_W-1:0] hi_w [NUM_T];
  logic              t0_split, set1;
  logic [1:0]        flag_q;
  logic              baud_q;

  tmr_sync #(.W(NUM_T), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst(rst), .d_i(cnt_pin_i), .q_o(cnt_lvl));
  tmr_sync #(.W(NUM_T), .STAGES(SYNC_STAGES)) u_irq_sync (
    .clk(clk), .rst(rst), .d_i(irq_pin_i), .q_o(irq_lvl));

  always_ff @(posedge clk) begin
    if (rst) cnt_prev <= '0;
    else     cnt_prev <= cnt_lvl;
  end
  assign cnt_fall = cnt_prev & ~cnt_lvl;

  always_comb begin
    for (int i = 0; i < NUM_T; i++) begin
      gate[i] = mode_cfg_i[CFG_W*i+3];
      src[i]  = mode_cfg_i[CFG_W*i+2];
      md[i]   = tmr_mode_e'(mode_cfg_i[CFG_W*i +: 2]);
      ev[i]   = src[i] ? cnt_fall[i] : tick_i;
      en[i]   = run_i[i] & (~gate[i] | irq_lvl[i]);
    end
  end

  assign t0_split  = (md[0] == TM_SPLIT);
  assign inc_lo[0] = ev[0] & en[0];
  assign inc_hi[0] = t0_split & tick_i & run_i[1];
  assign inc_lo[1] = ev[1] & en[1] & (md[1] != TM_SPLIT);
  assign inc_hi[1] = 1'b0;

  for (genvar gi = 0; gi < NUM_T; gi++) begin : g_unit
    tmr_unit #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_unit (
      .clk(clk), .rst(rst), .mode_i(md[gi]),
      .inc_lo_i(inc_lo[gi]), .inc_hi_i(inc_hi[gi]),
      .wr_lo_i(wr_sel_i[2*gi]), .wr_hi_i(wr_sel_i[2*gi+1]),
      .wr_data_i(wr_data_i),
      .lo_o(lo_w[gi]), .hi_o(hi_w[gi]),
      .ovf_o(ovf[gi]), .ovf_hi_o(ovf_hi[gi]));
  end

  assign set1 = t0_split ? ovf_hi[0] : (ovf[1] | ovf_hi[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      baud_q <= 1'b0;
    end else begin
      flag_q[0] <= ovf[0] | (flag_q[0] & ~flag_clr_i[0]);
      flag_q[1] <= set1   | (flag_q[1] & ~flag_clr_i[1]);
      baud_q    <= ovf[1];
    end
  end

  assign t0_cnt_o     = {hi_w[0], lo_w[0]};
  assign t1_cnt_o     = {hi_w[1], lo_w[1]};
  assign flag_o       = flag_q;
  assign baud_pulse_o = baud_q;

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i[0] && !ovf[0]) |=> !flag_q[0]);
  // R9
  t1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (md[1] == TM_SPLIT && wr_sel_i[3:2] == 2'b00) |=> ($stable(t1_cnt_o) && !baud_q));
  // R8
  split_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (t0_split && !ovf_hi[0] && !flag_q[1]) |=> !flag_q[1]);
  // R3
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i[0] && wr_sel_i[1:0] == 2'b00) |=> $stable(t0_cnt_o[BYTE_W-1:0]));
endmodule

// File: tb/tb_tmr_pair_top.sv
`timescale 1ns/1ps
module tb_tmr_pair_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic [7:0]  mode_cfg_i = 8'h11;
  logic [1:0]  run_i = 2'b00;
  logic [1:0]  cnt_pin_i = 2'b00;
  logic [1:0]  irq_pin_i = 2'b00;
  logic [3:0]  wr_sel_i = 4'b0;
  logic [7:0]  wr_data_i = 8'h00;
  logic [1:0]  flag_clr_i = 2'b00;
  logic [15:0] t0_cnt_o, t1_cnt_o;
  logic [1:0]  flag_o;
  logic        baud_pulse_o;

  int vectors = 0;
  int fails   = 0;
  int baud_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_pair_top dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .mode_cfg_i(mode_cfg_i),
    .run_i(run_i), .cnt_pin_i(cnt_pin_i), .irq_pin_i(irq_pin_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .flag_clr_i(flag_clr_i),
    .t0_cnt_o(t0_cnt_o), .t1_cnt_o(t1_cnt_o), .flag_o(flag_o),
    .baud_pulse_o(baud_pulse_o));

  always @(negedge clk) if (!rst && baud_pulse_o) baud_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk); wr_sel_i = 4'(1 << sel); wr_data_i = d;
    @(negedge clk); wr_sel_i = 4'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr_i = 2'b11;
    @(negedge clk); flag_clr_i = 2'b00;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  function automatic logic [16:0] model(input int m, input int hi, input int lo, input int n);
    int s, r, nh, nl;
    logic f;
    nh = hi; nl = lo; f = 1'b0;
    case (m)
      0: begin
        s = hi * 32 + (lo % 32) + n; f = (s >= 8192); s = s % 8192;
        nh = s / 32; nl = (lo / 32) * 32 + s % 32;
      end
      1: begin
        s = hi * 256 + lo + n; f = (s >= 65536); s = s % 65536;
        nh = s / 256; nl = s % 256;
      end
      2: begin
        if (n < 256 - lo) nl = lo + n;
        else begin
          r = (n - (256 - lo)) % (256 - hi); nl = hi + r; f = 1'b1;
        end
      end
      default: begin
        s = lo + n; f = (s >= 256); nl = s % 256;
      end
    endcase
    return {f, nh[7:0], nl[7:0]};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic [16:0] e;
    logic [15:0] pre [4];
    int nlist [4];
    pre[0] = 16'h0000; pre[1] = 16'hFFF0; pre[2] = 16'hFEFC; pre[3] = 16'h80FF;
    nlist[0] = 1; nlist[1] = 5; nlist[2] = 40; nlist[3] = 300;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 t0", 32'(t0_cnt_o), 0);
    chk("R1 t1", 32'(t1_cnt_o), 0);
    chk("R1 flags", 32'(flag_o), 0);
    chk("R1 baud", 32'(baud_pulse_o), 0);

    // R4 R5 R6 R13 sweep
    for (int t = 0; t < 2; t++)
      for (int m = 0; m < 3; m++)
        for (int p = 0; p < 4; p++)
          for (int k = 0; k < 4; k++) begin
            mode_cfg_i = (t == 0) ? {4'b0001, 4'(m)} : {4'(m), 4'b0001};
            run_i = 2'(1 << t);
            wr(2*t, pre[p][7:0]);
            wr(2*t+1, pre[p][15:8]);
            clr_flags();
            ticks(nlist[k]);
            e = model(m, int'(pre[p][15:8]), int'(pre[p][7:0]), nlist[k]);
            chk(m == 0 ? "R4 count" : (m == 1 ? "R5 count" : "R6 count"),
                32'(t == 0 ? t0_cnt_o : t1_cnt_o), 32'(e[15:0]));
            chk(m == 0 ? "R4 flag" : (m == 1 ? "R5 flag" : "R6 flag"),
                32'(flag_o[t]), 32'(e[16]));
          end

    // R11 baud pulses from timer 1 reload, period 4
    mode_cfg_i = 8'h21; run_i = 2'b10;
    wr(2, 8'hFC); wr(3, 8'hFC); clr_flags();
    base = baud_cnt;
    ticks(20);
    @(negedge clk);
    chk("R11 pulses", 32'(baud_cnt - base), 5);

    // R7 R8 split: timer 1 wraps, flag 1 untouched, high byte counts
    mode_cfg_i = 8'h13; run_i = 2'b10;
    wr(0, 8'hF0); wr(1, 8'h00); wr(2, 8'hFE); wr(3, 8'hFF); clr_flags();
    base = baud_cnt;
    ticks(5);
    chk("R8 flag1", 32'(flag_o[1]), 0);
    chk("R7 hi byte", 32'(t0_cnt_o), 32'h05F0);
    chk("R8 t1 count", 32'(t1_cnt_o), 32'h0003);
    @(negedge clk);
    chk("R11 split baud", 32'(baud_cnt - base), 1);
    run_i = 2'b11;
    wr(1, 8'hFE);
    ticks(20);
    chk("R7 both bytes", 32'(t0_cnt_o), 32'h1204);
    chk("R7 flags", 32'(flag_o), 32'h3);

    // R9 timer 1 in mode 11 holds
    mode_cfg_i = 8'h31; run_i = 2'b11;
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h34); wr(3, 8'h12); clr_flags();
    base = baud_cnt;
    ticks(10);
    @(negedge clk);
    chk("R9 hold", 32'(t1_cnt_o), 32'h1234);
    chk("R9 t0 runs", 32'(t0_cnt_o), 10);
    chk("R9 no flag", 32'(flag_o[1]), 0);
    chk("R9 no baud", 32'(baud_cnt - base), 0);

    // R3 gate and run
    mode_cfg_i = 8'h19; run_i = 2'b01; irq_pin_i = 2'b00;
    wr(0, 8'h00); wr(1, 8'h00);
    repeat (3) @(negedge clk);
    ticks(10);
    chk("R3 gated low", 32'(t0_cnt_o), 0);
    irq_pin_i = 2'b01;
    repeat (3) @(negedge clk);
    ticks(10);
    chk("R3 gated high", 32'(t0_cnt_o), 10);
    run_i = 2'b00;
    ticks(10);
    chk("R3 run off", 32'(t0_cnt_o), 10);
    irq_pin_i = 2'b00;

    // R2 external pin edges, tick ignored
    mode_cfg_i = 8'h15; run_i = 2'b01;
    wr(0, 8'h00); wr(1, 8'h00);
    @(negedge clk); tick_i = 1'b1;
    for (int q = 0; q < 7; q++) begin
      cnt_pin_i[0] = 1'b1; repeat (3) @(negedge clk);
      cnt_pin_i[0] = 1'b0; repeat (3) @(negedge clk);
    end
    tick_i = 1'b0;
    @(negedge clk);
    chk("R2 pin edges", 32'(t0_cnt_o), 7);
    mode_cfg_i = 8'h11;
    ticks(6);
    chk("R2 tick source", 32'(t0_cnt_o), 13);

    // R10 flag clear and set priority
    mode_cfg_i = 8'h11; run_i = 2'b01;
    wr(0, 8'hFF); wr(1, 8'hFF); clr_flags();
    @(negedge clk); tick_i = 1'b1; flag_clr_i = 2'b01;
    @(negedge clk); tick_i = 1'b0; flag_clr_i = 2'b00;
    chk("R10 set wins", 32'(flag_o[0]), 1);
    chk("R10 wrap count", 32'(t0_cnt_o), 0);
    @(negedge clk); flag_clr_i = 2'b10;
    @(negedge clk); flag_clr_i = 2'b00;
    chk("R10 other flag kept", 32'(flag_o[0]), 1);
    @(negedge clk); flag_clr_i = 2'b01;
    @(negedge clk); flag_clr_i = 2'b00;
    chk("R10 cleared", 32'(flag_o[0]), 0);

    // R12 write suppresses counting
    wr(0, 8'h00); wr(1, 8'h10);
    @(negedge clk); tick_i = 1'b1; wr_sel_i = 4'b0001; wr_data_i = 8'h55;
    @(negedge clk); tick_i = 1'b0; wr_sel_i = 4'b0;
    chk("R12 write wins", 32'(t0_cnt_o), 32'h1055);
    ticks(1);
    chk("R12 resumes", 32'(t0_cnt_o), 32'h1056);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule